// File: doc/BRIEF.md
# Span Card Control and Status Registers

This block is the byte-wide register file of a four-span T1/E1 line card. It sits on a simple local bus with an address, a write strobe, a read strobe and 8-bit data in each direction. A small window of five byte offsets holds the timing-source selector, the card control word, the span indicator lamps and two single-bit flags. These registers drive the loopback, line-mode and sync pins of the data path directly.

The block also merges two interrupt causes into one active-low card interrupt. The first is an internal pending flag, which a one-cycle periodic tick sets and an acknowledge write clears. The second is the external framer interrupt, which passes only when its own enable bit is set. The base offset serves two purposes: a write loads the timing selector, and a read returns interrupt status. The pending flag is a two-state machine. Its states are IRQ_IDLE and IRQ_PEND. The transition IDLE to PEND happens on a tick. The transition PEND to IDLE happens on an acknowledge with no tick in the same cycle.

Top module: `span_ctl_regs`

## Requirements
- R1: After reset, sync_sel is 0, all control outputs are 0, led is 0x00, test2 and late_rev are 0, irq_n is 1, and a status read gives 0x00.
- R2: A write to offset 0x400 with a byte value 0 to 4 loads sync_sel with that value (0 free-run, 1..4 span 1..4). Any byte above 4 loads 0.
- R3: A read of offset 0x400 returns status in rdata during the same cycle: bit 0 is interrupt enable, bit 1 is the internal pending flag, bit 2 is the framer_irq input level, and bits 7:3 are 0.
- R4: A write to offset 0x401 stores bits 6:0. Bit 0 is interrupt enable and bit 2 is framer interrupt enable. The other bits drive outputs: bit 1 drives test1, bit 3 master_sync, bit 4 e1_mode (1 = E1), bit 5 rmt_loop and bit 6 lcl_loop.
- R5: Writing 1 to bit 7 at offset 0x401 clears the pending flag. Bit 7 is not stored, and bits 6:0 of the same write are loaded.
- R6: irq_n is 0 exactly when interrupt enable is 1 and either the pending flag is set, or framer interrupt enable is 1 and framer_irq is 1.
- R7: A one-cycle tick sets the pending flag. When a tick and an acknowledge occur in the same cycle, the flag ends up set.
- R8: A write to offset 0x402 loads all 8 led bits. Bit 2k is the green lamp and bit 2k+1 is the red lamp of span k+1.
- R9: Bit 0 of a write to 0x403 drives test2, and bit 0 of a write to 0x404 drives late_rev. The upper bits of these writes are ignored.
- R10: Writes to offsets other than 0x400..0x404 change no output. rdata is 0x00 for reads of any offset other than 0x400, and is 0x00 whenever rd_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 11 | Byte offset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| tick | input | 1 | Periodic interrupt request, one cycle |
| framer_irq | input | 1 | External framer interrupt, active high |
| irq_n | output | 1 | Card interrupt, active low |
| sync_sel | output | 3 | Timing source select |
| test1 | output | 1 | Test pin 1 |
| master_sync | output | 1 | External sync enable |
| e1_mode | output | 1 | 1 = E1 divisor, 0 = T1 |
| rmt_loop | output | 1 | Remote serial loopback |
| lcl_loop | output | 1 | Local buffer loopback |
| led | output | 8 | Span lamps, green/red pairs |
| test2 | output | 1 | Test pin 2 |
| late_rev | output | 1 | Later framer silicon mode |

## Verification
The assertions assume that reset is applied from time zero, and that the inputs are binary and change only away from the rising clock edge. They also assume that tick is a single-cycle pulse and that wr_en is asserted for exactly one cycle per write. The bench drives every input on the falling edge. It raises wr_en and tick for one cycle only, and it releases reset before any traffic. The bench samples each result one half period after the edge that registers it.

// File: rtl/span_ctl_pkg.sv
package span_ctl_pkg;
    localparam int ADDR_W  = 11;
    localparam int DATA_W  = 8;
    localparam int NREG    = 5;
    localparam int SYNC_W  = 3;
    localparam int SYNC_MAX = 4;
    localparam logic [ADDR_W-1:0] BASE_ADDR = 11'h400;

    // register index within the window
    localparam int IDX_SYNC = 0;
    localparam int IDX_CTL  = 1;
    localparam int IDX_LED  = 2;
    localparam int IDX_TST2 = 3;
    localparam int IDX_REV  = 4;

    // control word bit positions
    localparam int CB_IEN  = 0;
    localparam int CB_TST1 = 1;
    localparam int CB_FEN  = 2;
    localparam int CB_MSTR = 3;
    localparam int CB_E1   = 4;
    localparam int CB_RLB  = 5;
    localparam int CB_LLB  = 6;
    localparam int CB_ACK  = 7;

    typedef enum logic {IRQ_IDLE = 1'b0, IRQ_PEND = 1'b1} irq_state_t;
endpackage

// File: rtl/span_ctl_dec.sv
module span_ctl_dec
    import span_ctl_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int N  = NREG,
    parameter logic [AW-1:0] BASE = BASE_ADDR
) (
    input  logic [AW-1:0] addr,
    output logic [N-1:0]  sel
);
    // one select line per mapped byte offset
    for (genvar i = 0; i < N; i++) begin : g_sel
        assign sel[i] = (addr == BASE + AW'(i));
    end
endmodule

// File: rtl/span_ctl_irq.sv
module span_ctl_irq
    import span_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ack,
    output logic pend
);
    irq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (tick) state_d = IRQ_PEND;
            IRQ_PEND: if (ack && !tick) state_d = IRQ_IDLE;
            default:  state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend = (state_q == IRQ_PEND);
    end
endmodule

// File: rtl/span_ctl_regs.sv
module span_ctl_regs
    import span_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              tick,
    input  logic              framer_irq,
    output logic              irq_n,
    output logic [SYNC_W-1:0] sync_sel,
    output logic              test1,
    output logic              master_sync,
    output logic              e1_mode,
    output logic              rmt_loop,
    output logic              lcl_loop,
    output logic [DATA_W-1:0] led,
    output logic              test2,
    output logic              late_rev
);
    localparam int CTL_W = CB_ACK;

    logic [NREG-1:0]   sel;
    logic [NREG-1:0]   we;
    logic [CTL_W-1:0]  ctl_q;
    logic [SYNC_W-1:0] sync_q;
    logic [DATA_W-1:0] led_q;
    logic              tst2_q, rev_q;
    logic              ack, irq_pend;
    logic              led_we;

    span_ctl_dec #(.AW(ADDR_W), .N(NREG), .BASE(BASE_ADDR)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    assign we     = sel & {NREG{wr_en}};
    assign ack    = we[IDX_CTL] & wdata[CB_ACK];
    assign led_we = we[IDX_LED];

    span_ctl_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .ack   (ack),
        .pend  (irq_pend)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            ctl_q  <= '0;
            led_q  <= '0;
            tst2_q <= 1'b0;
            rev_q  <= 1'b0;
        end else begin
            if (we[IDX_SYNC])
                sync_q <= (wdata > DATA_W'(SYNC_MAX)) ? '0 : wdata[SYNC_W-1:0];
            if (we[IDX_CTL])  ctl_q  <= wdata[CTL_W-1:0];
            if (we[IDX_LED])  led_q  <= wdata;
            if (we[IDX_TST2]) tst2_q <= wdata[0];
            if (we[IDX_REV])  rev_q  <= wdata[0];
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en && sel[IDX_SYNC])
            rdata = {{(DATA_W-3){1'b0}}, framer_irq, irq_pend, ctl_q[CB_IEN]};
    end

    assign irq_n = ~(ctl_q[CB_IEN] & (irq_pend | (ctl_q[CB_FEN] & framer_irq)));

    assign sync_sel    = sync_q;
    assign test1       = ctl_q[CB_TST1];
    assign master_sync = ctl_q[CB_MSTR];
    assign e1_mode     = ctl_q[CB_E1];
    assign rmt_loop    = ctl_q[CB_RLB];
    assign lcl_loop    = ctl_q[CB_LLB];
    assign led         = led_q;
    assign test2       = tst2_q;
    assign late_rev    = rev_q;
endmodule

// File: rtl/span_ctl_chk.sv
module span_ctl_chk
    import span_ctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ien,
    input logic              fen,
    input logic              pend,
    input logic              tick,
    input logic              ack,
    input logic              framer_irq,
    input logic              irq_n,
    input logic [SYNC_W-1:0] sync_sel,
    input logic [DATA_W-1:0] led,
    input logic              led_we
);
    AST_IEN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> irq_n); // R6
    AST_FEN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (!fen && !pend) |-> irq_n); // R6
    AST_TICK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> pend); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !tick) |=> !pend); // R5
    AST_SYNC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_sel <= SYNC_W'(SYNC_MAX)); // R2
    AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !led_we |=> $stable(led)); // R8
endmodule

bind span_ctl_regs span_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ien        (ctl_q[0]),
    .fen        (ctl_q[2]),
    .pend       (irq_pend),
    .tick       (tick),
    .ack        (ack),
    .framer_irq (framer_irq),
    .irq_n      (irq_n),
    .sync_sel   (sync_sel),
    .led        (led),
    .led_we     (led_we)
);

// File: tb/tb_span_ctl_regs.sv
`timescale 1ns/1ps
module tb_span_ctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        tick = 1'b0, framer_irq = 1'b0;
    logic        irq_n, test1, master_sync, e1_mode, rmt_loop, lcl_loop;
    logic [2:0]  sync_sel;
    logic [7:0]  led;
    logic        test2, late_rev;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    span_ctl_regs dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .tick(tick), .framer_irq(framer_irq),
        .irq_n(irq_n), .sync_sel(sync_sel), .test1(test1),
        .master_sync(master_sync), .e1_mode(e1_mode), .rmt_loop(rmt_loop),
        .lcl_loop(lcl_loop), .led(led), .test2(test2), .late_rev(late_rev)
    );

    // observed bus: {sync(3), test1, master, e1, rmt, lcl, led(8), test2, late}
    function automatic logic [17:0] obs();
        return {sync_sel, test1, master_sync, e1_mode, rmt_loop, lcl_loop,
                led, test2, late_rev};
    endfunction

    localparam int NV = 12;
    // {addr(11), data(8), expected obs(18)}
    localparam logic [36:0] VEC [NV] = '{
        {11'h400, 8'h03, 3'd3, 5'b00000, 8'h00, 1'b0, 1'b0},  // R2
        {11'h400, 8'h07, 3'd0, 5'b00000, 8'h00, 1'b0, 1'b0},  // R2 above 4
        {11'h400, 8'h04, 3'd4, 5'b00000, 8'h00, 1'b0, 1'b0},  // R2 edge
        {11'h402, 8'hA5, 3'd4, 5'b00000, 8'hA5, 1'b0, 1'b0},  // R8
        {11'h401, 8'h7A, 3'd4, 5'b11111, 8'hA5, 1'b0, 1'b0},  // R4
        {11'h403, 8'hFF, 3'd4, 5'b11111, 8'hA5, 1'b1, 1'b0},  // R9
        {11'h404, 8'h01, 3'd4, 5'b11111, 8'hA5, 1'b1, 1'b1},  // R9
        {11'h405, 8'hFF, 3'd4, 5'b11111, 8'hA5, 1'b1, 1'b1},  // R10
        {11'h000, 8'h55, 3'd4, 5'b11111, 8'hA5, 1'b1, 1'b1},  // R10
        {11'h402, 8'h3C, 3'd4, 5'b11111, 8'h3C, 1'b1, 1'b1},  // R8
        {11'h401, 8'h80, 3'd4, 5'b00000, 8'h3C, 1'b1, 1'b1},  // R5 bit7 not stored
        {11'h403, 8'hFE, 3'd4, 5'b00000, 8'h3C, 1'b0, 1'b1}   // R9 upper bits
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d, input logic tk);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; tick = tk;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 obs", 32'(obs()), 32'h0);
        check("R1 irq_n", 32'(irq_n), 32'h1);
        rst_n = 1'b1;
        rd(11'h400, r);
        check("R1 status", 32'(r), 32'h00);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][36:26], VEC[i][25:18], 1'b0);
            check("R2/R4/R5/R8/R9/R10 table", 32'(obs()), 32'(VEC[i][17:0]));
        end

        // R3/R6/R7 tick raises pending, visible in status and irq_n
        wr(11'h401, 8'h01, 1'b0);
        check("R6 enable only", 32'(irq_n), 32'h1);
        pulse_tick();
        check("R7 tick irq_n", 32'(irq_n), 32'h0);
        rd(11'h400, r);
        check("R3 status pending", 32'(r), 32'h03);
        // R5 acknowledge clears, other bits stored
        wr(11'h401, 8'h81, 1'b0);
        check("R5 ack irq_n", 32'(irq_n), 32'h1);
        rd(11'h400, r);
        check("R5 status after ack", 32'(r), 32'h01);
        // R7 tick wins over simultaneous ack
        pulse_tick();
        wr(11'h401, 8'h81, 1'b1);
        check("R7 tick priority", 32'(irq_n), 32'h0);
        wr(11'h401, 8'h81, 1'b0);
        check("R5 second ack", 32'(irq_n), 32'h1);
        // R6 framer gating
        @(negedge clk); framer_irq = 1'b1;
        #1 check("R6 framer gated off", 32'(irq_n), 32'h1);
        rd(11'h400, r);
        check("R3 framer level", 32'(r), 32'h05);
        wr(11'h401, 8'h05, 1'b0);
        check("R6 framer passes", 32'(irq_n), 32'h0);
        wr(11'h401, 8'h04, 1'b0);
        check("R6 master off", 32'(irq_n), 32'h1);
        @(negedge clk); framer_irq = 1'b0;
        // R10 unmapped and idle reads
        rd(11'h401, r);
        check("R10 read 0x401", 32'(r), 32'h00);
        rd(11'h7FF, r);
        check("R10 read unmapped", 32'(r), 32'h00);
        @(negedge clk); addr = 11'h400; rd_en = 1'b0;
        #1 check("R10 rd_en low", 32'(rdata), 32'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule